// File: doc/BRIEF.md
# Integer ALU with comparison flags

This block is the arithmetic and logic stage of a small load/store processor. It combines two operands with one of seven functions chosen by a 4-bit operation code. Alongside the result it reports a zero flag and a signed-overflow flag. There is no clock: every output follows its inputs in the same cycle. Sign or zero extension of immediates happens before the operands arrive.

Addition and subtraction share one carry-lookahead adder. For subtraction the second operand is inverted and the carry input is forced high. Branch equality is tested by subtracting and looking at the zero flag. The signed less-than function reuses the same difference and corrects its sign with the overflow indication. Unsigned arithmetic variants use the same datapath; the consumer simply disregards the overflow flag.

A decoder turns the operation code into a small set of strobes. The datapath contains a bitwise logic unit, the adder and the final result selector.

Top module: `aluCore`

## Requirements
- R1: Code 0000 gives A AND B, 0001 gives A OR B, 0011 gives A XOR B and 1100 gives NOR of A and B, each bit by bit.
- R2: Code 0010 gives A plus B modulo 2^WIDTH.
- R3: Code 0110 gives A minus B modulo 2^WIDTH, formed as A plus the inverted B plus a carry-in of 1.
- R4: For codes 0010 and 0110 the overflow output is the XOR of the carry into the most significant bit and the carry out of it. It is therefore 1 exactly when the signed result is out of range. For every other code it is 0.
- R5: Code 0111 sets result bit 0 to 1 when A is less than B as signed numbers, including when A minus B overflows, and clears every other result bit.
- R6: The zero output is 1 exactly when all result bits are 0, for every code. Under code 0110, equal operands give zero = 1.
- R7: Any code not listed in R1 to R5 gives a result of 0, overflow 0 and zero 1.
- R8: The block holds no state. Outputs settle after an input change without any clock edge, and all-zero inputs give result 0, zero 1 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| opCode | input | 4 | Operation select |
| result | output | WIDTH | Function result |
| zero | output | 1 | High when the result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
Two flag functions act together with the arithmetic in a single evaluation: a subtraction can overflow and produce a zero-flag decision at once, and the less-than bit is decided from a difference that may itself have overflowed. The bench provokes both by sweeping every operand pair and every code on a 4-bit copy, and by using extreme 32-bit values such as the most negative number against 1 or against the most positive number. Each vector's result, overflow and zero are judged against values worked out from signed integer arithmetic in the bench.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_XOR = 4'b0011,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } aluOp_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_XOR = 2'd2,
    LOG_NOR = 2'd3
  } logicFn_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LOGIC = 2'd1,
    SRC_SUM   = 2'd2,
    SRC_LESS  = 2'd3
  } resSrc_e;

  typedef struct packed {
    logic     invertB;
    logicFn_e logicFn;
    resSrc_e  resSrc;
    logic     ovfEnable;
  } aluStrobes_t;

endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [3:0]  opCode,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes.invertB   = 1'b0;
    strobes.logicFn   = LOG_AND;
    strobes.resSrc    = SRC_NONE;
    strobes.ovfEnable = 1'b0;
    case (opCode)
      OP_AND: begin strobes.resSrc = SRC_LOGIC; strobes.logicFn = LOG_AND; end
      OP_OR:  begin strobes.resSrc = SRC_LOGIC; strobes.logicFn = LOG_OR;  end
      OP_XOR: begin strobes.resSrc = SRC_LOGIC; strobes.logicFn = LOG_XOR; end
      OP_NOR: begin strobes.resSrc = SRC_LOGIC; strobes.logicFn = LOG_NOR; end
      OP_ADD: begin strobes.resSrc = SRC_SUM;   strobes.ovfEnable = 1'b1;  end
      OP_SUB: begin
        strobes.resSrc    = SRC_SUM;
        strobes.invertB   = 1'b1;
        strobes.ovfEnable = 1'b1;
      end
      OP_SLT: begin strobes.resSrc = SRC_LESS; strobes.invertB = 1'b1; end
      default: ;
    endcase

    // R4: overflow is only reported for the arithmetic result path
    assert_ovf_arith_only_R4: assert (!strobes.ovfEnable || strobes.resSrc == SRC_SUM)
      else $error("overflow strobe outside add/subtract");
    // R5: a comparison always runs the adder in subtract mode
    assert_less_uses_sub_R5: assert (strobes.resSrc != SRC_LESS || strobes.invertB)
      else $error("less-than without subtract");
  end

endmodule

// File: rtl/aluLogic.sv
module aluLogic
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logicFn_e         logicFn,
  output logic [WIDTH-1:0] logicOut
);

  for (genvar i = 0; i < WIDTH; i++) begin : bitLane
    logic andBit, orBit, xorBit;
    assign andBit = opA[i] & opB[i];
    assign orBit  = opA[i] | opB[i];
    assign xorBit = opA[i] ^ opB[i];
    assign logicOut[i] = (logicFn == LOG_AND) ? andBit :
                         (logicFn == LOG_OR)  ? orBit  :
                         (logicFn == LOG_XOR) ? xorBit : ~orBit;
  end

endmodule

// File: rtl/aluAdder.sv
module aluAdder #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             subtract,
  output logic [WIDTH-1:0] sum,
  output logic             carryIntoMsb,
  output logic             carryOut
);

  localparam int NGROUPS = WIDTH / GROUP;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] genBit;
  logic [WIDTH-1:0] propBit;
  logic [WIDTH:0]   carry;

  always_comb begin
    logic groupIn;
    logic chainP;
    logic term;
    bEff    = subtract ? ~opB : opB;
    genBit  = opA & bEff;
    propBit = opA ^ bEff;
    carry   = '0;
    carry[0] = subtract;
    for (int g = 0; g < NGROUPS; g++) begin
      groupIn = carry[g*GROUP];
      for (int k = 1; k <= GROUP; k++) begin
        term = 1'b0;
        for (int j = 0; j < k; j++) begin
          chainP = 1'b1;
          for (int m = j + 1; m < k; m++) chainP = chainP & propBit[g*GROUP+m];
          term = term | (genBit[g*GROUP+j] & chainP);
        end
        chainP = 1'b1;
        for (int m = 0; m < k; m++) chainP = chainP & propBit[g*GROUP+m];
        carry[g*GROUP+k] = term | (chainP & groupIn);
      end
    end
    sum          = propBit ^ carry[WIDTH-1:0];
    carryIntoMsb = carry[WIDTH-1];
    carryOut     = carry[WIDTH];

    // R4: the carry pair around the MSB flags exactly the sign-rule cases
    assert_ovf_sign_R4: assert ((carryIntoMsb ^ carryOut) ==
        ((opA[WIDTH-1] == bEff[WIDTH-1]) && (sum[WIDTH-1] != opA[WIDTH-1])))
      else $error("overflow carries disagree with sign rule");
    // R3: subtracting a value from itself yields zero with a carry out
    assert_sub_self_zero_R3: assert (!(subtract && opA == opB) || (sum == '0 && carryOut))
      else $error("self subtract not zero");
    // R6: a zero difference only arises from equal operands
    assert_zero_means_equal_R6: assert (!(subtract && sum == '0) || opA == opB)
      else $error("zero difference from unequal operands");
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);

  logic [WIDTH-1:0] logicOut;
  logic [WIDTH-1:0] sumOut;
  logic             carryIntoMsb;
  logic             carryOut;

  aluLogic #(.WIDTH(WIDTH)) logicUnit (
    .opA(opA), .opB(opB), .logicFn(strobes.logicFn), .logicOut(logicOut)
  );

  aluAdder #(.WIDTH(WIDTH), .GROUP(GROUP)) adder (
    .opA(opA), .opB(opB), .subtract(strobes.invertB),
    .sum(sumOut), .carryIntoMsb(carryIntoMsb), .carryOut(carryOut)
  );

  always_comb begin
    logic rawOvf;
    logic lessBit;
    rawOvf  = carryIntoMsb ^ carryOut;
    lessBit = sumOut[WIDTH-1] ^ rawOvf;
    case (strobes.resSrc)
      SRC_LOGIC: result = logicOut;
      SRC_SUM:   result = sumOut;
      SRC_LESS:  result = {{(WIDTH-1){1'b0}}, lessBit};
      default:   result = '0;
    endcase
    overflow = strobes.ovfEnable & rawOvf;
    zero     = ~|result;

    // R5: a comparison never leaves bits above bit 0 set
    assert_less_upper_clear_R5: assert (strobes.resSrc != SRC_LESS || result[WIDTH-1:1] == '0)
      else $error("less-than upper bits set");
    // R7: an idle selection produces a zero result with the zero flag raised
    assert_idle_zero_R7: assert (strobes.resSrc != SRC_NONE || (zero && !overflow))
      else $error("unlisted code gave non-zero output");
  end

endmodule

// File: rtl/aluCore.sv
module aluCore
  import aluPkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       opCode,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);

  aluStrobes_t strobes;

  aluControl control (
    .opCode(opCode), .strobes(strobes)
  );

  aluDatapath #(.WIDTH(WIDTH), .GROUP(GROUP)) datapath (
    .opA(opA), .opB(opB), .strobes(strobes),
    .result(result), .zero(zero), .overflow(overflow)
  );

endmodule

// File: tb/tb_aluCore.sv
`timescale 1ns/1ps
module tb_aluCore;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] aBig = '0, bBig = '0;
  logic [3:0]  opBig = '0;
  logic [31:0] resBig;
  logic        zeroBig, ovfBig;

  logic [3:0] aSml = '0, bSml = '0;
  logic [3:0] opSml = '0;
  logic [3:0] resSml;
  logic       zeroSml, ovfSml;

  aluCore #(.WIDTH(32), .GROUP(4)) dut (
    .opA(aBig), .opB(bBig), .opCode(opBig),
    .result(resBig), .zero(zeroBig), .overflow(ovfBig)
  );

  aluCore #(.WIDTH(4), .GROUP(2)) dutSmall (
    .opA(aSml), .opB(bSml), .opCode(opSml),
    .result(resSml), .zero(zeroSml), .overflow(ovfSml)
  );

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string reqOf(logic [3:0] op);
    case (op)
      4'b0000, 4'b0001, 4'b0011, 4'b1100: return "R1";
      4'b0010: return "R2";
      4'b0110: return "R3";
      4'b0111: return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic void refAlu(int w, longint a, longint b, logic [3:0] op,
                                 output longint res, output bit ovf);
    longint mask, sa, sb, s, maxS, minS;
    mask = (64'sd1 <<< w) - 1;
    maxS = (64'sd1 <<< (w - 1)) - 1;
    minS = -(64'sd1 <<< (w - 1));
    sa = a[w-1] ? a - (64'sd1 <<< w) : a;
    sb = b[w-1] ? b - (64'sd1 <<< w) : b;
    ovf = 1'b0;
    case (op)
      4'b0000: res = a & b;
      4'b0001: res = a | b;
      4'b0011: res = a ^ b;
      4'b1100: res = ~(a | b) & mask;
      4'b0010: begin s = sa + sb; res = s & mask; ovf = (s > maxS) || (s < minS); end
      4'b0110: begin s = sa - sb; res = s & mask; ovf = (s > maxS) || (s < minS); end
      4'b0111: res = (sa < sb) ? 64'd1 : 64'd0;
      default: res = 0;
    endcase
  endfunction

  task automatic runBig(logic [31:0] a, logic [31:0] b, logic [3:0] op);
    longint er;
    bit eo;
    @(negedge clk);
    aBig = a; bBig = b; opBig = op;
    #1;
    refAlu(32, longint'(a), longint'(b), op, er, eo);
    check($sformatf("%s result a=%h b=%h op=%b", reqOf(op), a, b, op), longint'(resBig), er);
    check($sformatf("R4 overflow a=%h b=%h op=%b", a, b, op), longint'(ovfBig), longint'(eo));
    check($sformatf("R6 zero a=%h b=%h op=%b", a, b, op), longint'(zeroBig), longint'(er == 0));
  endtask

  task automatic runSmall(logic [3:0] a, logic [3:0] b, logic [3:0] op);
    longint er;
    bit eo;
    @(negedge clk);
    aSml = a; bSml = b; opSml = op;
    #1;
    refAlu(4, longint'(a), longint'(b), op, er, eo);
    check($sformatf("%s small result a=%h b=%h op=%b", reqOf(op), a, b, op), longint'(resSml), er);
    check($sformatf("R4 small overflow a=%h b=%h op=%b", a, b, op), longint'(ovfSml), longint'(eo));
    check($sformatf("R6 small zero a=%h b=%h op=%b", a, b, op), longint'(zeroSml), longint'(er == 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] corners [5];
    logic [3:0]  validOps [7];
    corners = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
    validOps = '{4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0110, 4'b0111, 4'b1100};

    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R8: all-zero inputs settle with no clock edge involved
    check("R8 zero-input result", longint'(resBig), 0);
    check("R8 zero-input zero flag", longint'(zeroBig), 1);
    check("R8 zero-input overflow", longint'(ovfBig), 0);
    rst = 1'b0;

    // R8: mid-cycle input change is reflected before the next edge
    @(posedge clk);
    #1;
    aBig = 32'h0000_00F0; bBig = 32'h0000_000F; opBig = 4'b0001;
    #0.5;
    check("R8 mid-cycle update", longint'(resBig), 64'hFF);

    // named corner cases
    runBig(32'h8000_0000, 32'h1, 4'b0111);   // R5 most negative below 1
    check("R5 min below one", longint'(resBig), 1);
    runBig(32'h7FFF_FFFF, 32'h8000_0000, 4'b0111);  // R5 overflowing compare
    check("R5 max not below min", longint'(resBig), 0);
    runBig(32'h7FFF_FFFF, 32'h1, 4'b0010);   // R4 positive overflow
    check("R4 max plus one overflows", longint'(ovfBig), 1);
    runBig(32'h8000_0000, 32'h1, 4'b0110);   // R4 negative overflow
    check("R4 min minus one overflows", longint'(ovfBig), 1);
    runBig(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b0110);  // R6 equality via subtract
    check("R6 equal operands zero", longint'(zeroBig), 1);
    runBig(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b1010);  // R7 unlisted code
    check("R7 unlisted result", longint'(resBig), 0);

    // exhaustive sweep of the 4-bit copy over every code
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          runSmall(4'(a), 4'(b), 4'(op));

    // 32-bit corner pairs under every code
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          runBig(corners[i], corners[j], 4'(op));

    // random 32-bit vectors over the listed codes
    for (int n = 0; n < 1500; n++)
      for (int k = 0; k < 7; k++)
        runBig($urandom, $urandom, validOps[k]);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule